// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

The block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in parallel lanes. It keeps a rounded, middle 16-bit slice of each 24-bit product. A 9-bit opcode chooses where each lane's pixel byte and coefficient come from. The choices are a packed byte per lane, the upper or lower byte of each 16-bit lane, or one coefficient broadcast to every lane. Two "wide" variants produce only two products and place each one in its own 32-bit half of the result.

Operands are presented with `in_valid`. The result is registered and appears one clock later with `out_valid`. The result register keeps its value while `in_valid` is low. An opcode outside the supported set yields an all-zero result.

Top module: `pmul8x16`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. A result is available exactly one clock after its operands.
- R3: When `in_valid` is low, `result` keeps its previous value whatever `op`, `src_a` and `src_b` carry.
- R4: With `op` = 9'h031, result bits [16k+15:16k] (k = 0..3) hold the rounded product of `src_a[8k+7:8k]` and `src_b[16k+15:16k]`.
- R5: Every lane product treats the pixel byte as unsigned and the coefficient as two's-complement signed. The value 128 is added to the 24-bit product, and bits 23:8 of the sum are kept as the 16-bit lane value.
- R6: With `op` = 9'h033, every lane k uses `src_a[8k+7:8k]` with the single coefficient `src_b[31:16]`.
- R7: With `op` = 9'h035, every lane k uses `src_a[8k+7:8k]` with the single coefficient `src_b[15:0]`.
- R8: With `op` = 9'h036, lane k uses the upper byte `src_a[16k+15:16k+8]` with `src_b[16k+15:16k]`, for four lanes.
- R9: With `op` = 9'h037, lane k uses the lower byte `src_a[16k+7:16k]` with `src_b[16k+15:16k]`, for four lanes.
- R10: With `op` = 9'h038, two lanes (k = 0, 1) use `src_a[16k+15:16k+8]` and `src_b[16k+15:16k]`. Each 16-bit value is placed at result bits [32k+22:32k+7], and every other result bit is 0.
- R11: With `op` = 9'h039, the two lanes use `src_a[16k+7:16k]` and are placed as in R10.
- R12: Any other `op` value with `in_valid` high gives an all-zero `result`, and `out_valid` is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 9 | Variant select opcode |
| src_a | input | 64 | Pixel operand (only the low 32 bits are used by the packed and wide variants) |
| src_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | `result` holds a new product set |
| result | output | 64 | Registered partitioned product |

## Verification
The only state is the output register, so a fault in lane selection, rounding or placement shows up at `result` one clock after the operands that exposed it. Any lane mixed up with another, or a byte taken from the wrong half, changes some 16-bit field of that result. A hold fault shows as `result` changing during an idle cycle, and a valid-tracking fault shows as `out_valid` out of step with `in_valid` one clock later. The bench compares both outputs against a behavioural model on every clock. It covers every opcode, broadcast coefficients, sign extremes and the exact half-step rounding points.

// File: rtl/pmul8x16_pkg.sv
package pmul8x16_pkg;

    localparam int OPC_W = 9;

    localparam logic [OPC_W-1:0] OPC_PLAIN   = 9'h031;
    localparam logic [OPC_W-1:0] OPC_BC_HI   = 9'h033;
    localparam logic [OPC_W-1:0] OPC_BC_LO   = 9'h035;
    localparam logic [OPC_W-1:0] OPC_HB      = 9'h036;
    localparam logic [OPC_W-1:0] OPC_LB      = 9'h037;
    localparam logic [OPC_W-1:0] OPC_WIDE_HB = 9'h038;
    localparam logic [OPC_W-1:0] OPC_WIDE_LB = 9'h039;

    // Where each lane's pixel byte comes from.
    typedef enum logic [1:0] {
        PIX_PACKED  = 2'd0,   // byte k of the packed pixel word
        PIX_LANE_HI = 2'd1,   // upper byte of 16-bit lane k
        PIX_LANE_LO = 2'd2    // lower byte of 16-bit lane k
    } pix_src_e;

    // Where each lane's coefficient comes from.
    typedef enum logic [1:0] {
        COEF_LANE  = 2'd0,    // 16-bit lane k
        COEF_BC_HI = 2'd1,    // upper half of the low word, broadcast
        COEF_BC_LO = 2'd2     // lower half of the low word, broadcast
    } coef_src_e;

    typedef struct packed {
        logic      legal;
        logic      wide;
        pix_src_e  pix;
        coef_src_e coef;
    } dec_t;

    function automatic dec_t decode_op(input logic [OPC_W-1:0] op);
        dec_t d;
        d = '{legal: 1'b1, wide: 1'b0, pix: PIX_PACKED, coef: COEF_LANE};
        case (op)
            OPC_PLAIN:   ;
            OPC_BC_HI:   d.coef = COEF_BC_HI;
            OPC_BC_LO:   d.coef = COEF_BC_LO;
            OPC_HB:      d.pix  = PIX_LANE_HI;
            OPC_LB:      d.pix  = PIX_LANE_LO;
            OPC_WIDE_HB: begin d.pix = PIX_LANE_HI; d.wide = 1'b1; end
            OPC_WIDE_LB: begin d.pix = PIX_LANE_LO; d.wide = 1'b1; end
            default:     d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pmul_decode.sv
module pmul_decode
    import pmul8x16_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    output dec_t             dec
);

    always_comb begin
        dec = decode_op(op);
    end

endmodule

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
    import pmul8x16_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  pix_src_e                       pix_src,
    input  coef_src_e                      coef_src,
    input  logic [LANES*COEF_W-1:0]        src_a,
    input  logic [LANES*COEF_W-1:0]        src_b,
    output logic [LANES-1:0][PIX_W-1:0]    pix,
    output logic [LANES-1:0][COEF_W-1:0]   coef
);

    localparam int BC_HI_LSB = COEF_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PIX_W-1:0]  lane_pix;
        logic [COEF_W-1:0] lane_coef;

        always_comb begin
            case (pix_src)
                PIX_PACKED:  lane_pix = src_a[PIX_W*g +: PIX_W];
                PIX_LANE_HI: lane_pix = src_a[COEF_W*g + PIX_W +: PIX_W];
                default:     lane_pix = src_a[COEF_W*g +: PIX_W];
            endcase
        end

        always_comb begin
            case (coef_src)
                COEF_BC_HI: lane_coef = src_b[BC_HI_LSB +: COEF_W];
                COEF_BC_LO: lane_coef = src_b[0 +: COEF_W];
                default:    lane_coef = src_b[COEF_W*g +: COEF_W];
            endcase
        end

        assign pix[g]  = lane_pix;
        assign coef[g] = lane_coef;
    end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [COEF_W-1:0] coef,
    output logic [COEF_W-1:0] frac
);

    localparam int PROD_W = PIX_W + COEF_W;
    // Half of one output step: 1 at bit PIX_W-1.
    localparam logic signed [PROD_W:0] HALF =
        {{(PROD_W - PIX_W + 1){1'b0}}, 1'b1, {(PIX_W - 1){1'b0}}};

    logic signed [PROD_W:0] prod_s;
    logic signed [PROD_W:0] sum_s;
    logic                   unused_bits;

    always_comb begin
        prod_s = $signed({1'b0, pix}) * $signed(coef);
        sum_s  = prod_s + HALF;
        frac   = sum_s[PROD_W-1:PIX_W];
    end

    assign unused_bits = ^{sum_s[PIX_W-1:0], sum_s[PROD_W]};

endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
    import pmul8x16_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [OPC_W-1:0]         op,
    input  logic [LANES*COEF_W-1:0]  src_a,
    input  logic [LANES*COEF_W-1:0]  src_b,
    output logic                     out_valid,
    output logic [LANES*COEF_W-1:0]  result
);

    localparam int DATA_W     = LANES * COEF_W;
    localparam int WIDE_LANES = LANES / 2;
    localparam int WIDE_STEP  = 2 * COEF_W;
    localparam int WIDE_OFS   = PIX_W - 1;

    function automatic logic [DATA_W-1:0] wide_field_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < WIDE_LANES; k++) begin
            m[WIDE_STEP*k + WIDE_OFS +: COEF_W] = '1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] WIDE_MASK = wide_field_mask();

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    dec_t                          dec;
    logic [LANES-1:0][PIX_W-1:0]   pix_sel;
    logic [LANES-1:0][COEF_W-1:0]  coef_sel;
    logic [LANES-1:0][COEF_W-1:0]  frac;
    logic [DATA_W-1:0]             placed;
    state_t                        st_d, st_q;

    pmul_decode u_decode (
        .op  (op),
        .dec (dec)
    );

    pmul_operand_sel #(
        .LANES  (LANES),
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W)
    ) u_sel (
        .pix_src  (dec.pix),
        .coef_src (dec.coef),
        .src_a    (src_a),
        .src_b    (src_b),
        .pix      (pix_sel),
        .coef     (coef_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_mul
        pmul_lane #(
            .PIX_W  (PIX_W),
            .COEF_W (COEF_W)
        ) u_lane (
            .pix  (pix_sel[g]),
            .coef (coef_sel[g]),
            .frac (frac[g])
        );
    end

    // Result placement: packed 16-bit lanes, or one field per 32-bit half.
    always_comb begin
        placed = '0;
        if (dec.legal) begin
            if (dec.wide) begin
                for (int k = 0; k < WIDE_LANES; k++) begin
                    placed[WIDE_STEP*k + WIDE_OFS +: COEF_W] = frac[k];
                end
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    placed[COEF_W*k +: COEF_W] = frac[k];
                end
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = placed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R2: valid tracks the input one clock later.
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: idle cycles leave the result untouched.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R6, R7: broadcast variants feed the same coefficient to every lane.
    p_bcast_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.coef != COEF_LANE) |-> (coef_sel[0] == coef_sel[LANES-1]));

    // R10, R11: wide variants leave every bit outside their two fields at zero.
    p_wide_gaps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.legal && dec.wide) |=> ((result & ~WIDE_MASK) == '0));

    // R12: unsupported opcodes give an all-zero result.
    p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec.legal) |=> (result == '0));

endmodule

// File: tb/pmul8x16_bench.sv
`timescale 1ns/1ps
module pmul8x16_bench;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [8:0]  op;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        out_valid;
    logic [63:0] result;

    int          n_cmp;
    int          n_bad;
    bit          done;
    logic        exp_v;
    logic [63:0] exp_res;
    string       exp_tag;

    pmul8x16 u_pmul8x16 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Behavioural reference for one lane (R5).
    function automatic logic [15:0] rfrac(input logic [7:0] p, input logic [15:0] c);
        longint      v;
        logic [63:0] bits;
        v    = longint'(p) * longint'($signed(c)) + 128;
        bits = v;
        return bits[23:8];
    endfunction

    function automatic logic [63:0] rmodel(input logic [8:0] o, input logic [63:0] a,
                                           input logic [63:0] b);
        logic [63:0] r;
        r = 64'h0;
        case (o)
            9'h031: for (int k = 0; k < 4; k++) r[16*k +: 16] = rfrac(a[8*k +: 8], b[16*k +: 16]);
            9'h033: for (int k = 0; k < 4; k++) r[16*k +: 16] = rfrac(a[8*k +: 8], b[31:16]);
            9'h035: for (int k = 0; k < 4; k++) r[16*k +: 16] = rfrac(a[8*k +: 8], b[15:0]);
            9'h036: for (int k = 0; k < 4; k++) r[16*k +: 16] = rfrac(a[16*k+8 +: 8], b[16*k +: 16]);
            9'h037: for (int k = 0; k < 4; k++) r[16*k +: 16] = rfrac(a[16*k +: 8], b[16*k +: 16]);
            9'h038: for (int k = 0; k < 2; k++) r[32*k+7 +: 16] = rfrac(a[16*k+8 +: 8], b[16*k +: 16]);
            9'h039: for (int k = 0; k < 2; k++) r[32*k+7 +: 16] = rfrac(a[16*k +: 8], b[16*k +: 16]);
            default: r = 64'h0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [8:0] o);
        case (o)
            9'h031:  return "R4";
            9'h033:  return "R6";
            9'h035:  return "R7";
            9'h036:  return "R8";
            9'h037:  return "R9";
            9'h038:  return "R10";
            9'h039:  return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic compare();
        n_cmp++;
        if (out_valid !== exp_v || result !== exp_res) begin
            n_bad++;
            $display("FAIL %s (R2 valid): out_valid=%0b result=%h expected out_valid=%0b result=%h",
                     exp_tag, out_valid, result, exp_v, exp_res);
        end
    endtask

    // One clock: check the previous result, then drive new inputs.
    task automatic cycle(input logic v, input logic [8:0] o, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        op       = o;
        src_a    = a;
        src_b    = b;
        if (v) begin
            exp_res = rmodel(o, a, b);
            exp_tag = tag;
        end else begin
            exp_tag = "R3";
        end
        exp_v = v;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [8:0] legal_ops [7];
        n_cmp    = 0;
        n_bad    = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        op       = 9'h031;
        src_a    = 64'hFFFF_FFFF_FFFF_FFFF;
        src_b    = 64'h1234_5678_9ABC_DEF0;
        exp_v    = 1'b0;
        exp_res  = 64'h0;
        exp_tag  = "R1";
        legal_ops = '{9'h031, 9'h033, 9'h035, 9'h036, 9'h037, 9'h038, 9'h039};

        // R1: reset state, with active inputs during reset.
        repeat (3) @(negedge clk);
        compare();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R5: rounding points and sign extremes.
        cycle(1'b1, 9'h031, 64'h0000_0000_0101_0101, 64'hFF7F_FF80_007F_0080, "R5");
        cycle(1'b1, 9'h031, 64'h0000_0000_FFFF_FFFF, 64'h8000_7FFF_8000_7FFF, "R5");
        cycle(1'b1, 9'h031, 64'h0000_0000_0000_FF00, 64'h0001_FFFF_0000_FFFF, "R5");
        cycle(1'b1, 9'h038, 64'h0000_0000_FF00_FF00, 64'h0000_0000_8000_7FFF, "R10");
        cycle(1'b1, 9'h039, 64'h0000_0000_00FF_00FF, 64'h0000_0000_7FFF_8000, "R11");
        cycle(1'b1, 9'h033, 64'hFFFF_FFFF_FF80_0102, 64'hAAAA_AAAA_8000_5555, "R6");
        cycle(1'b1, 9'h035, 64'hFFFF_FFFF_FF80_0102, 64'hAAAA_AAAA_8000_7FFF, "R7");

        // R3: idle cycles with changing garbage on the inputs.
        for (int i = 0; i < 20; i++) cycle(1'b0, 9'($urandom), rnd64(), rnd64(), "R3");

        // Every supported variant with random operands, with idle gaps.
        for (int j = 0; j < 7; j++) begin
            for (int i = 0; i < 150; i++) begin
                cycle(1'b1, legal_ops[j], rnd64(), rnd64(), tag_of(legal_ops[j]));
                if (i % 16 == 5) cycle(1'b0, 9'($urandom), rnd64(), rnd64(), "R3");
            end
        end

        // Mixed back-to-back opcodes, including unsupported ones (R12).
        for (int i = 0; i < 300; i++) begin
            logic [8:0] o;
            o = (i % 3 == 0) ? 9'($urandom) : legal_ops[$urandom % 7];
            cycle(1'b1, o, rnd64(), rnd64(), tag_of(o));
        end
        cycle(1'b1, 9'h000, rnd64(), rnd64(), "R12");
        cycle(1'b1, 9'h032, rnd64(), rnd64(), "R12");
        cycle(1'b1, 9'h1FF, rnd64(), rnd64(), "R12");
        cycle(1'b0, 9'h031, rnd64(), rnd64(), "R3");
        cycle(1'b0, 9'h031, rnd64(), rnd64(), "R3");

        @(negedge clk);
        compare();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule